// File: doc/BRIEF.md
# Data-Derived Frequency Acquisition Loop

This block pulls an oscillator onto the rate of incoming serial data when no crystal reference exists. Every data transition arrives as a one-cycle pulse in the oscillator clock domain. A prescaler turns each group of `REF_DIV` pulses into one reference tick. Because the data toggles on about half of its bits, the time between two ticks should equal `REF_DIV * DENS_RECIP` oscillator cycles once the oscillator runs at the data rate.

A period comparator counts the oscillator cycles between consecutive ticks and compares that count with the ideal count. Only the sign of the difference reaches a 10-bit tuning word, which moves by one step per comparison and saturates at its ends. A first-order noise-shaping modulator splits the tuning word into integer and fractional parts. It emits a narrow coarse-tuning code whose long-run mean equals the tuning word divided by 2^fractional bits. A lock detector raises its flag once eight comparisons in a row fall within a programmable tolerance. While the flag is high, the tuning word is frozen.

Top module: `fllacq_top`

## Requirements
- R1: One reference tick is formed on every `REF_DIV`-th `data_edge` pulse after reset. The tuning word can change only in the cycle after such a tick.
- R2: The first tick after reset only starts the measurement and never changes the tuning word or the lock state.
- R3: For each later tick, let the measured period be the number of clock cycles since the previous tick, and let the ideal count be `REF_DIV*DENS_RECIP`. If the period is shorter than the ideal count, the tuning word rises by 1. If it is longer, the word falls by 1. If they are equal, the word is unchanged.
- R4: The tuning word saturates: it never rises above 1023 and never falls below 0.
- R5: A comparison is within tolerance when |period − ideal| <= `tol`. The lock flag rises after the eighth consecutive in-tolerance comparison. That eighth comparison still applies its step.
- R6: An out-of-tolerance comparison clears the run of in-tolerance comparisons. If the block is locked, it also drops the lock flag.
- R7: While the lock flag is high, comparisons do not move the tuning word. This includes the comparison that drops the lock.
- R8: Let `I` be the upper `DAC_INT_W` bits of the tuning word. Each cycle, `dac_code` is either `I` or `I+1`, based on the tuning word of the previous cycle. Over any 64 consecutive cycles with a constant tuning word, the 64 codes sum exactly to the tuning word (4 integer and 6 fractional bits).
- R9: During reset, `acc_word` is 512, `locked` is 0 and `dac_code` is 0.
- R10: The tuning word changes by at most one step per cycle, and only in the cycle after a valid comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| data_edge | input | 1 | One-cycle pulse per received data transition |
| tol | input | TOL_W | Lock tolerance in oscillator cycles |
| acc_word | output | ACC_W | Frequency tuning word |
| dac_code | output | DAC_INT_W+1 | Noise-shaped coarse-tuning code |
| locked | output | 1 | Frequency lock flag |

## Verification
The properties assume that `data_edge` is already sampled into the oscillator domain, with one pulse per transition. They also assume that `tol` changes only between comparisons, so each comparison sees a single tolerance. The stimulus drives a pulse train with a fixed spacing of one, two or three cycles. It changes the spacing or `tol` only just after a tick, so every measured period is an exact multiple of the spacing. The noise-shaping checks sample only after the tuning word has settled and edges have stopped, so the 64-cycle sum sees a constant input.

// File: rtl/fllacq_pkg.sv
`timescale 1ns/1ps
package fllacq_pkg;

  // Direction requested by one period comparison
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/fllacq_ref_div.sv
`timescale 1ns/1ps
// Divides the data-transition pulse stream into a stochastic reference tick.
module fllacq_ref_div #(
  parameter int REF_DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  output logic ref_tick
);

  localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(REF_DIV - 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = edge_in && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (edge_in) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
    ref_tick = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (edge_in) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fllacq_period_cmp.sv
`timescale 1ns/1ps
// Counts oscillator cycles between reference ticks and grades the period.
module fllacq_period_cmp
  import fllacq_pkg::*;
#(
  parameter int REF_DIV    = 1024,
  parameter int DENS_RECIP = 2,
  parameter int TOL_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [TOL_W-1:0] tol,
  output logic             cmp_valid,
  output step_e            step,
  output logic             in_tol
);

  localparam int EXP_CNT = REF_DIV * DENS_RECIP;
  localparam int CNT_W   = $clog2(EXP_CNT * 4);
  localparam int CMP_W   = ((CNT_W > TOL_W) ? CNT_W : TOL_W) + 1;
  localparam logic [CNT_W:0]   EXP_V   = (CNT_W+1)'(EXP_CNT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             armed_q, armed_d;
  logic [CNT_W:0]   meas;
  logic [CNT_W:0]   mag;

  always_comb begin
    meas = {1'b0, cyc_q} + 1'b1;
    if (meas < EXP_V) begin
      step = STEP_UP;
      mag  = EXP_V - meas;
    end else if (meas > EXP_V) begin
      step = STEP_DOWN;
      mag  = meas - EXP_V;
    end else begin
      step = STEP_HOLD;
      mag  = '0;
    end
    in_tol    = CMP_W'(mag) <= CMP_W'(tol);
    cmp_valid = ref_tick && armed_q;

    armed_d = armed_q | ref_tick;
    if (ref_tick) begin
      cyc_d = '0;
    end else if (cyc_q != CNT_MAX) begin
      cyc_d = cyc_q + 1'b1;
    end else begin
      cyc_d = cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cyc_q   <= cyc_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/fllacq_tune_ctrl.sv
`timescale 1ns/1ps
// Sign-step tuning accumulator with run-length lock detection and freeze.
module fllacq_tune_ctrl
  import fllacq_pkg::*;
#(
  parameter int ACC_W    = 10,
  parameter int ACC_INIT = 512,
  parameter int LOCK_RUN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  step_e            step,
  input  logic             in_tol,
  output logic [ACC_W-1:0] acc_word,
  output logic             locked
);

  localparam int RUN_W = (LOCK_RUN > 1) ? $clog2(LOCK_RUN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [ACC_W-1:0] ACC_MAX  = '1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             lock_q, lock_d;

  always_comb begin
    acc_d  = acc_q;
    run_d  = run_q;
    lock_d = lock_q;
    if (cmp_valid) begin
      if (lock_q) begin
        if (!in_tol) begin
          lock_d = 1'b0;
          run_d  = '0;
        end
      end else begin
        case (step)
          STEP_UP:   if (acc_q != ACC_MAX) acc_d = acc_q + 1'b1;
          STEP_DOWN: if (acc_q != '0)      acc_d = acc_q - 1'b1;
          default:   acc_d = acc_q;
        endcase
        if (in_tol) begin
          if (run_q == RUN_LAST) begin
            lock_d = 1'b1;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= ACC_W'(ACC_INIT);
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (cmp_valid) begin
      acc_q  <= acc_d;
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign acc_word = acc_q;
  assign locked   = lock_q;

endmodule

// File: rtl/fllacq_dsm.sv
`timescale 1ns/1ps
// First-order noise shaper: integer part plus carry of a fractional accumulator.
module fllacq_dsm #(
  parameter int ACC_W = 10,
  parameter int INT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_word,
  output logic [INT_W:0]   dac_code
);

  localparam int FRAC_W = ACC_W - INT_W;

  logic [INT_W-1:0] int_part;
  logic [INT_W:0]   code_q, code_d;

  assign int_part = acc_word[ACC_W-1:FRAC_W];

  generate
    if (FRAC_W > 0) begin : g_shaped
      logic [FRAC_W-1:0] sig_q, sig_d;
      logic [FRAC_W:0]   sum;
      always_comb begin
        sum    = {1'b0, sig_q} + {1'b0, acc_word[FRAC_W-1:0]};
        sig_d  = sum[FRAC_W-1:0];
        code_d = {1'b0, int_part} + {{INT_W{1'b0}}, sum[FRAC_W]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sig_q <= '0;
        end else begin
          sig_q <= sig_d;
        end
      end
    end else begin : g_plain
      always_comb begin
        code_d = {1'b0, int_part};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign dac_code = code_q;

endmodule

// File: rtl/fllacq_top.sv
`timescale 1ns/1ps
module fllacq_top
  import fllacq_pkg::*;
#(
  parameter int REF_DIV    = 1024,
  parameter int DENS_RECIP = 2,
  parameter int ACC_W      = 10,
  parameter int ACC_INIT   = 512,
  parameter int DAC_INT_W  = 4,
  parameter int TOL_W      = 8,
  parameter int LOCK_RUN   = 8
) (
  input  logic                 osc_clk,
  input  logic                 rst_n,
  input  logic                 data_edge,
  input  logic [TOL_W-1:0]     tol,
  output logic [ACC_W-1:0]     acc_word,
  output logic [DAC_INT_W:0]   dac_code,
  output logic                 locked
);

  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       ref_tick;
  logic       cmp_valid;
  step_e      step;
  logic       in_tol;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  fllacq_ref_div #(.REF_DIV(REF_DIV)) div_i (
    .clk      (osc_clk),
    .rst_n    (rst_core_n),
    .edge_in  (data_edge),
    .ref_tick (ref_tick)
  );

  fllacq_period_cmp #(
    .REF_DIV    (REF_DIV),
    .DENS_RECIP (DENS_RECIP),
    .TOL_W      (TOL_W)
  ) cmp_i (
    .clk       (osc_clk),
    .rst_n     (rst_core_n),
    .ref_tick  (ref_tick),
    .tol       (tol),
    .cmp_valid (cmp_valid),
    .step      (step),
    .in_tol    (in_tol)
  );

  fllacq_tune_ctrl #(
    .ACC_W    (ACC_W),
    .ACC_INIT (ACC_INIT),
    .LOCK_RUN (LOCK_RUN)
  ) tune_i (
    .clk       (osc_clk),
    .rst_n     (rst_core_n),
    .cmp_valid (cmp_valid),
    .step      (step),
    .in_tol    (in_tol),
    .acc_word  (acc_word),
    .locked    (locked)
  );

  fllacq_dsm #(.ACC_W(ACC_W), .INT_W(DAC_INT_W)) dsm_i (
    .clk      (osc_clk),
    .rst_n    (rst_core_n),
    .acc_word (acc_word),
    .dac_code (dac_code)
  );

endmodule

// File: rtl/fllacq_checker.sv
`timescale 1ns/1ps
module fllacq_checker #(
  parameter int ACC_W = 10,
  parameter int INT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc_word,
  input logic [INT_W:0]   dac_code,
  input logic             locked,
  input logic             cmp_valid
);

  localparam int FRAC_W = ACC_W - INT_W;

  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  // R10: at most one step per cycle
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (acc_word == $past(acc_word) ||
            acc_word == $past(acc_word) + 1'b1 ||
            acc_word == $past(acc_word) - 1'b1));

  // R1 / R10: tuning word moves only after a valid comparison
  a_r10_change_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && !$stable(acc_word)) |-> $past(cmp_valid));

  // R7: frozen while locked
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(locked)) |-> $stable(acc_word));

  // R5: lock rises only on a comparison
  a_r5_lock_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $rose(locked)) |-> $past(cmp_valid));

  // R6: lock drops only on a comparison
  a_r6_unlock_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $fell(locked)) |-> $past(cmp_valid));

  // R8: code is the previous integer part or one above it
  a_r8_dac_range: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (dac_code == {1'b0, $past(acc_word[ACC_W-1:FRAC_W])} ||
            dac_code == {1'b0, $past(acc_word[ACC_W-1:FRAC_W])} + 1'b1));

endmodule

bind fllacq_top fllacq_checker #(.ACC_W(ACC_W), .INT_W(DAC_INT_W)) chk_i (
  .clk       (osc_clk),
  .rst_n     (rst_core_n),
  .acc_word  (acc_word),
  .dac_code  (dac_code),
  .locked    (locked),
  .cmp_valid (cmp_valid)
);

// File: tb/fllacq_top_tb_top.sv
`timescale 1ns/1ps
module fllacq_top_tb_top;

  localparam int REF_DIV = 16;   // ideal period = 32 cycles
  localparam int NROW    = 11;

  logic       osc_clk;
  logic       rst_n;
  logic       data_edge;
  logic [7:0] tol;
  logic [9:0] acc_word;
  logic [4:0] dac_code;
  logic       locked;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  fllacq_top #(.REF_DIV(REF_DIV)) dut_i (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .data_edge (data_edge),
    .tol       (tol),
    .acc_word  (acc_word),
    .dac_code  (dac_code),
    .locked    (locked)
  );

  initial osc_clk = 1'b0;
  always #5 osc_clk = ~osc_clk;

  // spacing, tol, ref periods, expected acc, expected lock (cumulative from reset)
  localparam int VEC [NROW][5] = '{
    '{1,  0, 5, 516, 0},   // R2 first discarded, R3 four rises
    '{3,  0, 3, 513, 0},   // R3 falls
    '{2,  0, 8, 513, 1},   // R3 equal holds, R5 lock after eight
    '{3,  0, 2, 512, 0},   // R6 unlock, R7 no step on unlocking compare
    '{3, 16, 8, 504, 1},   // R5 |diff|==tol counts, eighth still steps
    '{3, 16, 4, 504, 1},   // R7 frozen
    '{1, 15, 3, 506, 0},   // R5 |diff|==tol+1 out, R6 unlock
    '{2,  0, 5, 506, 0},
    '{1,  0, 1, 507, 0},   // R6 run cleared
    '{2,  0, 7, 507, 0},   // R6 only seven in a row
    '{2,  0, 1, 507, 1}    // R5 eighth
  };

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; data_edge = 1'b0; tol = 8'd0;
    repeat (3) @(negedge osc_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge osc_clk);
  endtask

  task automatic drive_edges(int sp, int nedge);
    for (int e = 0; e < nedge; e++) begin
      for (int c = 0; c < sp; c++) begin
        @(negedge osc_clk);
        data_edge = (c == sp - 1);
      end
    end
  endtask

  task automatic settle();
    @(posedge osc_clk);
    #2;
  endtask

  task automatic dsm_sum(string req, int exp_sum, int lo);
    int s;
    s = 0;
    @(negedge osc_clk);
    data_edge = 1'b0;
    repeat (3) @(negedge osc_clk);
    for (int k = 0; k < 64; k++) begin
      @(negedge osc_clk);
      s += int'(dac_code);
      if (dac_code != 5'(lo) && dac_code != 5'(lo + 1))
        chk(req, int'(dac_code), lo);
    end
    chk(req, s, exp_sum);
  endtask

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    rst_n = 1'b0; data_edge = 1'b0; tol = 8'd0;
    repeat (3) @(negedge osc_clk);
    chk("R9 acc", int'(acc_word), 512);
    chk("R9 lock", int'(locked), 0);
    chk("R9 dac", int'(dac_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge osc_clk);

    // R2 first period discarded, R1 tick on sixteenth edge
    drive_edges(1, REF_DIV);
    settle();
    chk("R2 first tick", int'(acc_word), 512);
    drive_edges(1, REF_DIV - 1);
    settle();
    chk("R1 fifteen edges", int'(acc_word), 512);
    drive_edges(1, 1);
    settle();
    chk("R1 sixteenth edge, R3 rise", int'(acc_word), 513);

    // table walk
    do_reset();
    for (int r = 0; r < NROW; r++) begin
      tol = 8'(VEC[r][1]);
      drive_edges(VEC[r][0], VEC[r][2] * REF_DIV);
      settle();
      chk($sformatf("R3/R5/R6/R7 row %0d acc", r), int'(acc_word), VEC[r][3]);
      chk($sformatf("R5/R6 row %0d lock", r), int'(locked), VEC[r][4]);
    end
    dsm_sum("R8 sum 507", 507, 7);

    // R4 upper saturation
    do_reset();
    drive_edges(1, 520 * REF_DIV);
    settle();
    chk("R4 top", int'(acc_word), 1023);
    chk("R4 top lock", int'(locked), 0);
    dsm_sum("R8 sum 1023", 1023, 15);

    // R4 lower saturation
    do_reset();
    drive_edges(3, 520 * REF_DIV);
    settle();
    chk("R4 bottom", int'(acc_word), 0);
    dsm_sum("R8 sum 0", 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule